// File: doc/BRIEF.md
# Descriptor-Chained DMA Command Sequencer

This block runs a single DMA channel from a chain of 16-byte command descriptors stored in memory. Software loads the command pointer with the address of the first descriptor, then sets the run bit through the control register. The sequencer then reads each descriptor through a 32-bit read port and decodes its opcode.

An output-type command becomes a transfer request that carries the descriptor's address and byte count. Once that request is accepted, the sequencer advances the pointer to the next descriptor. A stop command ends the chain. An illegal opcode, or any command this channel does not implement, halts the chain and raises an error flag. The data movement itself happens downstream of the transfer port.

Top module: `dma_cmd_seq`

## Requirements
- R1: After synchronous reset the command pointer is 0, the status word is 0, and the error flag, memory read request and transfer valid are all low.
- R2: A descriptor is read as four consecutive 32-bit reads at pointer, pointer+4, pointer+8 and pointer+12. A read is consumed in each cycle where both the request and the read valid are high. The read request and transfer valid are never high together. In the word at pointer+0, bits [15:0] hold the byte count, bits [23:16] the command bits and bits [31:24] the key byte. The word at pointer+4 holds the data address.
- R3: For opcode 0 or 1 (key byte bits [7:4]), the sequencer raises a transfer request carrying the descriptor's address and count. The last flag is set only for opcode 1. All request fields stay stable until the request is accepted (valid and ready both high).
- R4: One cycle after a transfer is accepted, the command pointer equals its old value plus 16, and the next descriptor is then fetched from that address.
- R5: An opcode 0 or 1 command is rejected when key bits [2:0] are nonzero or command bits [5:0] are nonzero. A rejected command issues no transfer, leaves the pointer unchanged, clears the active bit and sets the error flag.
- R6: Opcode 7 (stop) clears the active bit without moving the pointer and without raising the error flag.
- R7: An opcode above 7 sets the dead bit (status bit 11), clears the active bit and sets the error flag.
- R8: Opcodes 2 to 6 are unsupported: they set the error flag and clear the active bit, but leave the dead bit clear.
- R9: The wake bit (status bit 8) is set by a control write with data bit 8 high, and it is cleared when the next descriptor is decoded.
- R10: A write to the pointer register (select 0) takes effect only while both the run bit (status bit 15) and the active bit (status bit 10) are clear. Writes to the status register (select 1) have no effect.
- R11: A control write (select 2) loads the run bit from data bit 15. Setting the run bit while it was clear starts the chain: in that same clock edge the active bit is set, the dead bit and error flag are cleared, and fetching begins at the current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 pointer, 1 status, 2 control |
| reg_wr_data | input | 32 | Register write data |
| cmd_ptr | output | 32 | Current command pointer |
| status | output | 16 | Channel status: 15 run, 11 dead, 10 active, 8 wake |
| mem_rd_req | output | 1 | Descriptor read request |
| mem_rd_addr | output | 32 | Descriptor read byte address |
| mem_rd_valid | input | 1 | Read data valid, consumes one read |
| mem_rd_data | input | 32 | Read data, little-endian bytes |
| xfer_valid | output | 1 | Transfer request valid |
| xfer_addr | output | 32 | Transfer data address |
| xfer_count | output | 16 | Transfer byte count |
| xfer_last | output | 1 | Request came from an output-last command |
| xfer_ready | input | 1 | Downstream accepts the transfer |
| err | output | 1 | Chain halted on a rejected or illegal command |

## Verification
The bench builds the block with its default parameters: 32-bit address and data, 16-byte descriptors and 16-bit counts. With these values a four-read descriptor fetch is exercised in full, and a pointer step of 16 keeps every chain inside a 1 KB model memory. The memory model withholds read valid on every third cycle, and ready is dropped on a regular pattern. As a result, fetch stalls and held transfer requests both occur within short chains.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam int unsigned ST_WAKE   = 8;
  localparam int unsigned ST_ACTIVE = 10;
  localparam int unsigned ST_DEAD   = 11;
  localparam int unsigned ST_RUN    = 15;

  localparam logic [1:0] SEL_PTR  = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  // Descriptor image; lowest field sits in the least significant bits of word 0.
  typedef struct packed {
    logic [15:0] xfer_stat;
    logic [15:0] res_count;
    logic [31:0] arg;
    logic [31:0] addr;
    logic [7:0]  key;
    logic [7:0]  bits;
    logic [15:0] req_count;
  } desc_t;

  typedef enum logic [1:0] {
    ACT_XFER   = 2'd0,
    ACT_STOP   = 2'd1,
    ACT_REJECT = 2'd2,
    ACT_DEAD   = 2'd3
  } act_e;

endpackage

// File: rtl/dma_desc_fetch.sv
module dma_desc_fetch #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_i,
  input  logic [ADDR_W-1:0]       base_i,
  input  logic                    rd_valid_i,
  input  logic [DATA_W-1:0]       rd_data_i,
  output logic                    rd_req_o,
  output logic [ADDR_W-1:0]       rd_addr_o,
  output logic                    done_o,
  output logic [BEATS*DATA_W-1:0] desc_o
);
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int WORD_B = DATA_W / 8;

  logic [BEAT_W-1:0] beat_q;
  logic [DATA_W-1:0] words_q [BEATS];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req_o  <= 1'b0;
      rd_addr_o <= '0;
      beat_q    <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rd_req_o  <= 1'b1;
        rd_addr_o <= base_i;
        beat_q    <= '0;
      end else if (rd_req_o && rd_valid_i) begin
        if (beat_q == BEAT_W'(BEATS - 1)) begin
          rd_req_o <= 1'b0;
          done_o   <= 1'b1;
        end else begin
          rd_addr_o <= rd_addr_o + ADDR_W'(WORD_B);
          beat_q    <= beat_q + 1'b1;
        end
      end
    end
  end

  // Data path without reset so it can map to plain registers.
  always_ff @(posedge clk) begin
    if (rd_req_o && rd_valid_i) words_q[beat_q] <= rd_data_i;
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_pack
    assign desc_o[g*DATA_W +: DATA_W] = words_q[g];
  end

endmodule

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_seq_pkg::*;
(
  input  desc_t desc_i,
  output act_e  act_o,
  output logic  last_o
);
  logic [3:0] op;

  always_comb begin
    op     = desc_i.key[7:4];
    last_o = (op == 4'd1);
    if (op > 4'd7)       act_o = ACT_DEAD;
    else if (op == 4'd7) act_o = ACT_STOP;
    else if (op <= 4'd1) begin
      if ((desc_i.key[2:0] != 3'd0) || (desc_i.bits[5:0] != 6'd0)) act_o = ACT_REJECT;
      else                                                          act_o = ACT_XFER;
    end else act_o = ACT_REJECT;
  end

endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int DESC_BYTES = 16,
  parameter int CNT_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wr_data,
  output logic [ADDR_W-1:0] cmd_ptr,
  output logic [15:0]       status,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              xfer_valid,
  output logic [ADDR_W-1:0] xfer_addr,
  output logic [CNT_W-1:0]  xfer_count,
  output logic              xfer_last,
  input  logic              xfer_ready,
  output logic              err
);
  localparam int BEATS = DESC_BYTES / (DATA_W / 8);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_XFER} state_e;

  state_e                  state_q;
  logic                    run_q, active_q, dead_q, wake_q;
  logic                    go, acc, fetch_start, fetch_done;
  logic [ADDR_W-1:0]       ptr_next, fetch_base;
  logic [BEATS*DATA_W-1:0] desc_flat;
  desc_t                   desc;
  act_e                    act;
  logic                    last_cmd;

  always_comb begin
    go          = reg_wr_en && (reg_sel == SEL_CTRL) && reg_wr_data[ST_RUN]
                  && !run_q && (state_q == S_IDLE);
    acc         = xfer_valid && xfer_ready;
    ptr_next    = cmd_ptr + ADDR_W'(DESC_BYTES);
    fetch_start = go || acc;
    fetch_base  = go ? cmd_ptr : ptr_next;
  end

  dma_desc_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_fetch (
    .clk       (clk),
    .rst       (rst),
    .start_i   (fetch_start),
    .base_i    (fetch_base),
    .rd_valid_i(mem_rd_valid),
    .rd_data_i (mem_rd_data),
    .rd_req_o  (mem_rd_req),
    .rd_addr_o (mem_rd_addr),
    .done_o    (fetch_done),
    .desc_o    (desc_flat)
  );

  assign desc = desc_t'(desc_flat);

  dma_cmd_decode u_dec (
    .desc_i(desc),
    .act_o (act),
    .last_o(last_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      cmd_ptr    <= '0;
      run_q      <= 1'b0;
      active_q   <= 1'b0;
      dead_q     <= 1'b0;
      wake_q     <= 1'b0;
      err        <= 1'b0;
      xfer_valid <= 1'b0;
      xfer_addr  <= '0;
      xfer_count <= '0;
      xfer_last  <= 1'b0;
    end else begin
      if (reg_wr_en && (reg_sel == SEL_PTR) && !run_q && !active_q)
        cmd_ptr <= reg_wr_data[ADDR_W-1:0];
      unique case (state_q)
        S_IDLE: if (go) begin
          active_q <= 1'b1;
          dead_q   <= 1'b0;
          err      <= 1'b0;
          state_q  <= S_FETCH;
        end
        S_FETCH: if (fetch_done) begin
          wake_q <= 1'b0;
          unique case (act)
            ACT_XFER: begin
              xfer_valid <= 1'b1;
              xfer_addr  <= desc.addr[ADDR_W-1:0];
              xfer_count <= desc.req_count[CNT_W-1:0];
              xfer_last  <= last_cmd;
              state_q    <= S_XFER;
            end
            ACT_STOP: begin
              active_q <= 1'b0;
              state_q  <= S_IDLE;
            end
            ACT_REJECT: begin
              active_q <= 1'b0;
              err      <= 1'b1;
              state_q  <= S_IDLE;
            end
            ACT_DEAD: begin
              active_q <= 1'b0;
              dead_q   <= 1'b1;
              err      <= 1'b1;
              state_q  <= S_IDLE;
            end
          endcase
        end
        S_XFER: if (acc) begin
          xfer_valid <= 1'b0;
          cmd_ptr    <= ptr_next;
          state_q    <= S_FETCH;
        end
        default: state_q <= S_IDLE;
      endcase
      if (reg_wr_en && (reg_sel == SEL_CTRL)) begin
        run_q <= reg_wr_data[ST_RUN];
        if (reg_wr_data[ST_WAKE]) wake_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status            = '0;
    status[ST_RUN]    = run_q;
    status[ST_DEAD]   = dead_q;
    status[ST_ACTIVE] = active_q;
    status[ST_WAKE]   = wake_q;
  end

endmodule

// File: rtl/dma_cmd_seq_chk.sv
module dma_cmd_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int DESC_BYTES = 16,
  parameter int CNT_W      = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [1:0]        reg_sel,
  input logic [ADDR_W-1:0] cmd_ptr,
  input logic [15:0]       status,
  input logic              mem_rd_req,
  input logic              xfer_valid,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [CNT_W-1:0]  xfer_count,
  input logic              xfer_last,
  input logic              xfer_ready,
  input logic              err
);
  AST_XFER_HOLD: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && !xfer_ready |=> xfer_valid && $stable(xfer_addr)
      && $stable(xfer_count) && $stable(xfer_last)); // R3

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    xfer_valid && xfer_ready |=> cmd_ptr == $past(cmd_ptr) + ADDR_W'(DESC_BYTES)); // R4

  AST_PTR_GUARD: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en && reg_sel == 2'd0 && (status[15] || status[10])
      && !(xfer_valid && xfer_ready) |=> $stable(cmd_ptr)); // R10

  AST_FETCH_XFER_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && xfer_valid)); // R2

  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (rst)
    status[11] |-> !status[10] && !mem_rd_req && !xfer_valid); // R7

  AST_ERR_HALTED: assert property (@(posedge clk) disable iff (rst)
    err |-> !status[10] && !xfer_valid); // R5
endmodule

bind dma_cmd_seq dma_cmd_seq_chk #(.ADDR_W(ADDR_W), .DESC_BYTES(DESC_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .cmd_ptr(cmd_ptr),
  .status(status), .mem_rd_req(mem_rd_req), .xfer_valid(xfer_valid), .xfer_addr(xfer_addr),
  .xfer_count(xfer_count), .xfer_last(xfer_last), .xfer_ready(xfer_ready), .err(err)
);

// File: tb/test_dma_cmd_seq.sv
module test_dma_cmd_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wr_data = '0;
  logic [31:0] cmd_ptr;
  logic [15:0] status;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;
  logic        xfer_valid;
  logic [31:0] xfer_addr;
  logic [15:0] xfer_count;
  logic        xfer_last;
  logic        xfer_ready = 1'b0;
  logic        err;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;
  logic [31:0] mem [256];
  logic [31:0] m_ptr = '0;
  int m_beat = 0;
  logic [31:0] exp_addr[$];
  logic [15:0] exp_cnt[$];
  logic        exp_last[$];

  always #5 clk = ~clk;

  dma_cmd_seq i_dma_cmd_seq (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel), .reg_wr_data(reg_wr_data),
    .cmd_ptr(cmd_ptr), .status(status), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data), .xfer_valid(xfer_valid),
    .xfer_addr(xfer_addr), .xfer_count(xfer_count), .xfer_last(xfer_last),
    .xfer_ready(xfer_ready), .err(err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // Memory responder, ready pattern and per-clock reference comparison.
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      xfer_ready   = (cyc % 4) != 1;
      mem_rd_valid = 1'b0;
      if (!rst && mem_rd_req) begin
        chk("R2 fetch addr", mem_rd_addr, m_ptr + 32'(4 * m_beat));
        if ((cyc % 3) != 2) begin
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem[mem_rd_addr[9:2]];
          m_beat       = (m_beat + 1) % 4;
        end
      end
      if (!rst && xfer_valid && xfer_ready) begin
        if (exp_addr.size() == 0) begin
          chk("R3 unexpected transfer", xfer_addr, 32'hDEAD_DEAD);
        end else begin
          chk("R3 addr", xfer_addr, exp_addr.pop_front());
          chk("R3 count", 32'(xfer_count), 32'(exp_cnt.pop_front()));
          chk("R3 last", 32'(xfer_last), 32'(exp_last.pop_front()));
        end
        m_ptr = m_ptr + 32'd16;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  task automatic put_desc(input logic [31:0] at, input logic [7:0] key, input logic [7:0] bits,
                          input logic [15:0] cnt, input logic [31:0] addr);
    mem[at[9:2]]     = {key, bits, cnt};
    mem[at[9:2] + 1] = addr;
    mem[at[9:2] + 2] = 32'h5A5A_0000 | at;
    mem[at[9:2] + 3] = 32'hC3C3_3C3C;
  endtask

  task automatic expect_xfer(input logic [31:0] a, input logic [15:0] c, input logic l);
    exp_addr.push_back(a);
    exp_cnt.push_back(c);
    exp_last.push_back(l);
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_sel     = sel;
    reg_wr_data = data;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  // Stop the channel, load the pointer, start and wait for active to drop.
  task automatic run_prog(input logic [31:0] at, input logic wake);
    reg_write(2'd2, 32'h0);
    reg_write(2'd0, at);
    chk("R10 ptr load while idle", cmd_ptr, at);
    m_ptr  = at;
    m_beat = 0;
    reg_write(2'd2, wake ? 32'h8100 : 32'h8000);
    chk("R11 active set on start", 32'(status[10]), 32'd1);
    chk("R11 err cleared on start", 32'(err), 32'd0);
    if (wake) chk("R9 wake set", 32'(status[8]), 32'd1);
    for (int i = 0; i < 3000 && status[10]; i++) @(negedge clk);
    chk("R3 all transfers seen", 32'(exp_addr.size()), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ptr", cmd_ptr, 32'h0);
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 err", 32'(err), 32'h0);
    chk("R1 req/valid", {30'd0, mem_rd_req, xfer_valid}, 32'h0);

    reg_write(2'd1, 32'hFFFF_FFFF);
    chk("R10 status write ignored", 32'(status), 32'h0);

    // Chain with two output-more and one output-last, then stop.
    put_desc(32'h040, 8'h00, 8'h00, 16'h0020, 32'h0000_1000);
    put_desc(32'h050, 8'h00, 8'hC0, 16'h0008, 32'h0000_2004);
    put_desc(32'h060, 8'h10, 8'h00, 16'h0100, 32'h0000_3000);
    put_desc(32'h070, 8'h70, 8'h00, 16'h0000, 32'h0);
    expect_xfer(32'h1000, 16'h0020, 1'b0);
    expect_xfer(32'h2004, 16'h0008, 1'b0);
    expect_xfer(32'h3000, 16'h0100, 1'b1);
    run_prog(32'h040, 1'b1);
    chk("R6 ptr stays on stop", cmd_ptr, 32'h070);
    chk("R4 ptr advanced by 16 per transfer", cmd_ptr, 32'h040 + 32'd48);
    chk("R6 err clear", 32'(err), 32'd0);
    chk("R6 status run only", 32'(status), 32'h8000);
    chk("R9 wake cleared by decode", 32'(status[8]), 32'd0);

    reg_write(2'd0, 32'h200);
    chk("R10 ptr write ignored while run", cmd_ptr, 32'h070);

    // Nonzero key field.
    put_desc(32'h100, 8'h01, 8'h00, 16'h0010, 32'h4000);
    run_prog(32'h100, 1'b0);
    chk("R5 key reject err", 32'(err), 32'd1);
    chk("R5 key reject ptr", cmd_ptr, 32'h100);
    chk("R5 key reject status", 32'(status), 32'h8000);

    // Nonzero wait/branch/interrupt bits on output-last.
    put_desc(32'h180, 8'h10, 8'h04, 16'h0010, 32'h4000);
    run_prog(32'h180, 1'b0);
    chk("R5 bits reject err", 32'(err), 32'd1);
    chk("R5 bits reject ptr", cmd_ptr, 32'h180);

    // Opcode above 7, after one good transfer.
    put_desc(32'h200, 8'h00, 8'h00, 16'hFFFF, 32'hABCD_0000);
    put_desc(32'h210, 8'h90, 8'h00, 16'h0000, 32'h0);
    expect_xfer(32'hABCD_0000, 16'hFFFF, 1'b0);
    run_prog(32'h200, 1'b0);
    chk("R7 dead set", 32'(status), 32'h8800);
    chk("R7 err", 32'(err), 32'd1);
    chk("R7 ptr at bad descriptor", cmd_ptr, 32'h210);

    // Unsupported input-more opcode; restart after dead clears dead.
    put_desc(32'h280, 8'h20, 8'h00, 16'h0004, 32'h5000);
    run_prog(32'h280, 1'b0);
    chk("R8 err on unsupported", 32'(err), 32'd1);
    chk("R8 dead stays clear", 32'(status), 32'h8000);
    chk("R8 ptr unchanged", cmd_ptr, 32'h280);

    // No-op opcode is unsupported too; then a clean restart.
    put_desc(32'h300, 8'h60, 8'h00, 16'h0, 32'h0);
    run_prog(32'h300, 1'b0);
    chk("R8 no-op err", 32'(err), 32'd1);
    put_desc(32'h340, 8'h10, 8'h00, 16'h0001, 32'h0000_0007);
    put_desc(32'h350, 8'h70, 8'h00, 16'h0, 32'h0);
    expect_xfer(32'h7, 16'h0001, 1'b1);
    run_prog(32'h340, 1'b0);
    chk("R11 restart clears err", 32'(err), 32'd0);
    chk("R4 final ptr", cmd_ptr, 32'h350);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule